// File: doc/BRIEF.md
# Self-Supply and Fault Sequencer

This block is the supervisory state machine of an offline switching controller that draws its own supply from the high-voltage rail. It turns a high-voltage charging source on and off to hold the supply capacitor between two thresholds. It allows the power switch to run only once the supply has reached its upper level, and it raises a one-cycle soft-start trigger on every start. The supply-capacitor discharge from the upper to the lower level serves as the overload timer. If the overload flag is still set when the supply reaches the lower threshold, switching stops and the block sits in low-power standby until the supply collapses to the restart level. It then recharges and tries again.

An overvoltage flag taken at the sample strobe, or an external latch request, shuts switching off permanently. While latched, the block keeps regulating the supply between the restart level and the upper level. It leaves that state only when the supply falls below the reset level. All comparator flags arrive asynchronously and pass through a synchronizer. Every output is registered.

Top module: `supply_fault_seq`

## Requirements
- R1: A synchronous reset, or a set below-reset-level flag, puts the block in the startup state with the source enabled, switching disabled, standby clear and soft-start clear. The below-reset-level flag has priority over every other input.
- R2: In startup, switching stays disabled and the source stays enabled until the above-upper flag is seen. The block then enters running, with switching enabled and the source disabled.
- R3: Each entry into running from startup raises the soft-start trigger for exactly one clock. This covers a fresh power-up and a restart after overload standby.
- R4: While running, the source turns on when the below-lower flag is seen during discharge and turns off when the above-upper flag is seen. Switching stays enabled throughout.
- R5: While running, if the overload flag is set at the moment the below-lower flag is seen during discharge, the block enters standby. Switching and the source are disabled and the standby output is high.
- R6: The overload flag has no effect at any other time. If it clears before the lower threshold is reached, running continues and the source turns on as in R4.
- R7: In standby, the below-restart flag returns the block to startup with the source enabled and standby clear. After recharge, R2 and R3 apply again.
- R8: An overvoltage sample flag or an external latch request, in any state, puts the block in the latched state with switching disabled. There the source turns on at the below-restart flag and off at the above-upper flag.
- R9: The latched state is left only through the below-reset-level flag. Other flags, including the below-lower and overload flags, do not release it.
- R10: An input change is reflected on the outputs at the third rising clock edge after it, given two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_upper | input | 1 | Supply above upper threshold (async) |
| vcc_below_lower | input | 1 | Supply below lower threshold (async) |
| vcc_below_restart | input | 1 | Supply below restart level (async) |
| vcc_below_clear | input | 1 | Supply below reset level (async) |
| overload_flag | input | 1 | Feedback at maximum (async) |
| ovp_sample_flag | input | 1 | Overvoltage seen at sample strobe (async) |
| latch_request | input | 1 | External latch-off request (async) |
| src_enable | output | 1 | High-voltage charging source enable |
| switch_enable | output | 1 | Power switch pulses allowed |
| softstart_trig | output | 1 | One-cycle soft-start start pulse |
| standby_lowpwr | output | 1 | Low-power overload standby |

## Verification
The bench drives each flag midway between clock edges. Each result is due at the third rising edge that follows: two edges in the synchronizer and one in the registered state and output logic. The reference model keeps a two-entry history of input snapshots, so at each edge it steps on the inputs taken two edges earlier. Its outputs are compared with the design's outputs at every falling edge. Directed checks wait one cycle more than this latency before they sample. The latency check samples once just before the due edge and once just after it.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
package sfs_pkg;
  localparam int FLAG_CNT = 7;
  localparam int IX_HI  = 0;
  localparam int IX_LO  = 1;
  localparam int IX_RS  = 2;
  localparam int IX_CLR = 3;
  localparam int IX_OVL = 4;
  localparam int IX_OVP = 5;
  localparam int IX_EXT = 6;

  typedef enum logic [3:0] {
    ST_START = 4'b0001,
    ST_RUN   = 4'b0010,
    ST_STBY  = 4'b0100,
    ST_LATCH = 4'b1000
  } seq_state_t;
endpackage

// File: rtl/sfs_sync.sv
`timescale 1ns/1ps
module sfs_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_fsm.sv
`timescale 1ns/1ps
module sfs_fsm
  import sfs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [FLAG_CNT-1:0] flags,
  output logic                src_q,
  output logic                sw_q,
  output logic                ss_q,
  output logic                sb_q
);
  seq_state_t state_q, state_n;
  logic src_n, ss_n;

  logic hi, lo, rs, clr, ovl, ovp, ext;
  assign hi  = flags[IX_HI];
  assign lo  = flags[IX_LO];
  assign rs  = flags[IX_RS];
  assign clr = flags[IX_CLR];
  assign ovl = flags[IX_OVL];
  assign ovp = flags[IX_OVP];
  assign ext = flags[IX_EXT];

  always_comb begin
    state_n = state_q;
    src_n   = src_q;
    ss_n    = 1'b0;
    unique case (state_q)
      ST_START: begin
        src_n = 1'b1;
        if (hi) begin
          state_n = ST_RUN;
          src_n   = 1'b0;
          ss_n    = 1'b1;
        end
      end
      ST_RUN: begin
        if (hi) src_n = 1'b0;
        else if (lo && !src_q) begin
          if (ovl) state_n = ST_STBY;
          else     src_n   = 1'b1;
        end
      end
      ST_STBY: begin
        src_n = 1'b0;
        if (rs) begin
          state_n = ST_START;
          src_n   = 1'b1;
        end
      end
      ST_LATCH: begin
        if (hi)      src_n = 1'b0;
        else if (rs) src_n = 1'b1;
      end
      default: begin
        state_n = ST_START;
        src_n   = 1'b1;
      end
    endcase
    if (ovp || ext) begin
      state_n = ST_LATCH;
      ss_n    = 1'b0;
    end
    if (clr) begin
      state_n = ST_START;
      src_n   = 1'b1;
      ss_n    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_START;
      src_q   <= 1'b1;
      sw_q    <= 1'b0;
      ss_q    <= 1'b0;
      sb_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      src_q   <= src_n;
      sw_q    <= (state_n == ST_RUN);
      ss_q    <= ss_n;
      sb_q    <= (state_n == ST_STBY);
    end
  end

  assert_state_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_q));

  assert_clear_wins_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (state_q == ST_START) && src_q && !sw_q && !sb_q);

  assert_switch_only_running_R2: assert property (@(posedge clk) disable iff (rst)
    sw_q |-> (state_q == ST_RUN));

  assert_softstart_single_R3: assert property (@(posedge clk) disable iff (rst)
    ss_q |=> !ss_q);

  assert_overload_trip_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !src_q && !hi && lo && ovl && !ovp && !ext && !clr)
      |=> (state_q == ST_STBY) && !sw_q && !src_q && sb_q);

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCH && !clr) |=> (state_q == ST_LATCH) && !sw_q);
endmodule

// File: rtl/supply_fault_seq.sv
`timescale 1ns/1ps
module supply_fault_seq
  import sfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_above_upper,
  input  logic vcc_below_lower,
  input  logic vcc_below_restart,
  input  logic vcc_below_clear,
  input  logic overload_flag,
  input  logic ovp_sample_flag,
  input  logic latch_request,
  output logic src_enable,
  output logic switch_enable,
  output logic softstart_trig,
  output logic standby_lowpwr
);
  logic [FLAG_CNT-1:0] raw_flags, sync_flags;

  always_comb begin
    raw_flags         = '0;
    raw_flags[IX_HI]  = vcc_above_upper;
    raw_flags[IX_LO]  = vcc_below_lower;
    raw_flags[IX_RS]  = vcc_below_restart;
    raw_flags[IX_CLR] = vcc_below_clear;
    raw_flags[IX_OVL] = overload_flag;
    raw_flags[IX_OVP] = ovp_sample_flag;
    raw_flags[IX_EXT] = latch_request;
  end

  sfs_sync #(.WIDTH(FLAG_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (sync_flags)
  );

  sfs_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .flags (sync_flags),
    .src_q (src_enable),
    .sw_q  (switch_enable),
    .ss_q  (softstart_trig),
    .sb_q  (standby_lowpwr)
  );
endmodule

// File: tb/supply_fault_seq_tb_top.sv
`timescale 1ns/1ps
module supply_fault_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi = 0, lo = 0, rs = 0, clr = 0, ovl = 0, ovp = 0, ext = 0;
  logic src_enable, switch_enable, softstart_trig, standby_lowpwr;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  supply_fault_seq dut_i (
    .clk (clk), .rst (rst),
    .vcc_above_upper (hi), .vcc_below_lower (lo),
    .vcc_below_restart (rs), .vcc_below_clear (clr),
    .overload_flag (ovl), .ovp_sample_flag (ovp), .latch_request (ext),
    .src_enable (src_enable), .switch_enable (switch_enable),
    .softstart_trig (softstart_trig), .standby_lowpwr (standby_lowpwr)
  );

  // Reference model: 0 startup, 1 running, 2 standby, 3 latched
  int   m_st = 0;
  logic m_src = 1, m_sw = 0, m_ss = 0, m_sb = 0;
  logic [6:0] hist [$] = '{7'd0, 7'd0};

  always @(posedge clk) begin
    logic [6:0] u;
    int nst;
    logic nsrc, nss;
    u = hist[1];
    if (rst) begin
      m_st = 0; m_src = 1; m_sw = 0; m_ss = 0; m_sb = 0;
      hist = '{7'd0, 7'd0};
    end else begin
      nst = m_st; nsrc = m_src; nss = 0;
      if (u[3]) begin
        nst = 0; nsrc = 1;
      end else if (u[5] || u[6]) begin
        nst = 3;
        if (m_st == 0) nsrc = 1;
        else if (m_st == 2) nsrc = 0;
        else if (u[0]) nsrc = 0;
        else if (m_st == 3 && u[2]) nsrc = 1;
        else if (m_st == 1 && u[1] && !m_src && !u[4]) nsrc = 1;
      end else if (m_st == 0) begin
        if (u[0]) begin nst = 1; nsrc = 0; nss = 1; end
        else nsrc = 1;
      end else if (m_st == 1) begin
        if (u[0]) nsrc = 0;
        else if (u[1] && !m_src) begin
          if (u[4]) nst = 2; else nsrc = 1;
        end
      end else if (m_st == 2) begin
        if (u[2]) begin nst = 0; nsrc = 1; end else nsrc = 0;
      end else begin
        if (u[0]) nsrc = 0; else if (u[2]) nsrc = 1;
      end
      m_st = nst; m_src = nsrc; m_ss = nss;
      m_sw = (nst == 1); m_sb = (nst == 2);
      hist.push_front({ext, ovp, ovl, clr, rs, lo, hi});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 src_enable vs model", src_enable, m_src);
      chk("R2 switch_enable vs model", switch_enable, m_sw);
      chk("R3 softstart_trig vs model", softstart_trig, m_ss);
      chk("R5 standby_lowpwr vs model", standby_lowpwr, m_sb);
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 src after reset", src_enable, 1'b1);
    chk("R1 sw after reset", switch_enable, 1'b0);
    chk("R1 standby after reset", standby_lowpwr, 1'b0);
    repeat (5) @(negedge clk);
    chk("R2 no switching before upper", switch_enable, 1'b0);
    // R10 latency on startup exit
    hi = 1;
    repeat (2) @(negedge clk);
    chk("R10 not yet switching", switch_enable, 1'b0);
    @(negedge clk);
    chk("R10 switching at third edge", switch_enable, 1'b1);
    chk("R3 softstart raised", softstart_trig, 1'b1);
    chk("R2 source off at upper", src_enable, 1'b0);
    @(negedge clk);
    chk("R3 softstart single cycle", softstart_trig, 1'b0);
    // R6 transient overload clears before lower threshold
    hi = 0; ovl = 1; settle();
    ovl = 0; lo = 1; settle();
    chk("R6 source on, no trip", src_enable, 1'b1);
    chk("R6 still switching", switch_enable, 1'b1);
    // R6 overload during charging has no effect
    ovl = 1; settle(); ovl = 0;
    chk("R6 overload ignored while charging", switch_enable, 1'b1);
    lo = 0; hi = 1; settle();
    chk("R4 source off at upper", src_enable, 1'b0);
    // R5 overload trip
    hi = 0; ovl = 1; settle();
    lo = 1; settle();
    chk("R5 standby entered", standby_lowpwr, 1'b1);
    chk("R5 switching stopped", switch_enable, 1'b0);
    chk("R5 source off in standby", src_enable, 1'b0);
    // R7 restart from standby
    rs = 1; settle();
    chk("R7 source on at restart level", src_enable, 1'b1);
    chk("R7 standby cleared", standby_lowpwr, 1'b0);
    rs = 0; lo = 0; ovl = 0; hi = 1;
    repeat (3) @(negedge clk);
    chk("R3 softstart on overload restart", softstart_trig, 1'b1);
    settle();
    // R8 overvoltage latch
    hi = 0; ovp = 1; settle(); ovp = 0;
    chk("R8 latched no switching", switch_enable, 1'b0);
    rs = 1; settle(); rs = 0;
    chk("R8 source on at restart level", src_enable, 1'b1);
    hi = 1; settle(); hi = 0;
    chk("R8 source off at upper", src_enable, 1'b0);
    // R9 other flags do not release the latch
    lo = 1; ovl = 1; settle(); lo = 0; ovl = 0;
    hi = 1; settle();
    chk("R9 latch holds", switch_enable, 1'b0);
    clr = 1; settle();
    chk("R1 clear flag forces startup source", src_enable, 1'b1);
    clr = 0; settle();
    chk("R9 released into running", switch_enable, 1'b1);
    // R8 external latch request
    ext = 1; settle(); ext = 0; settle();
    chk("R8 external latch stops switching", switch_enable, 1'b0);
    clr = 1; hi = 0; settle(); clr = 0; settle();
    chk("R1 startup after clear", src_enable, 1'b1);
    chk("R1 no switching after clear", switch_enable, 1'b0);
    finish_run();
  end
endmodule